// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of dedicated external interrupt pins and turns each into an interrupt request according to a per-pin sense setting. There are four settings: low level, any change, falling edge and rising edge. In the three edge settings the pin is first brought into the I/O clock domain by a synchronizer. A qualifying transition on an enabled pin then sets a sticky flag, which drives the request until software clears it with a write-one strobe or the interrupt controller acknowledges it.

In low-level mode no flag is kept. The request is built without any clock from the raw pin and the enable, so it stays asserted for as long as the pin is held low. It also works while the I/O clock is gated off, which makes it usable as a wake-up source. The block sees only the pin level. A pin that the chip drives as an output therefore triggers in the same way as an external one, and software can raise an interrupt by writing the pin.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset every flag is 0, and with all enables at 0 every request is 0.
- R2: The sense field of pin i is bits [2i+1:2i] of `sense_cfg`: 00 means low level, 01 any change, 10 falling edge and 11 rising edge. In an edge mode, a matching transition on an enabled pin sets that pin's flag. With the default two synchronizer stages, the flag is still 0 after the second rising clock edge that follows the pin change and reads 1 after the third.
- R3: A transition that does not match the selected edge mode, or a transition on a pin whose enable is 0, leaves the flag at 0.
- R4: A flag stays set until a `flag_clr` or `irq_ack` bit for that pin is high at a rising clock edge. The flag then reads 0 after that edge. A pin returning to its previous level does not clear the flag.
- R5: If a new edge and a clear or acknowledge arrive at the same clock edge, the flag ends up set.
- R6: In low-level mode the request equals enable AND NOT pin, with no clock edge needed, and the flag stays 0.
- R7: In an edge mode the request equals enable AND flag. Clearing the enable hides the request but keeps the flag.
- R8: A pin records no edge at any clock edge where its sense field differs from the value sampled at the previous clock edge. A change of mode therefore never creates an event of its own.
- R9: While the I/O clock is stopped, pin transitions in an edge mode change neither the flag nor the request.
- R10: Each pin's flag and request depend only on that pin's own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock; may be stopped |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NUM_PINS | Raw, asynchronous pin levels |
| int_en | input | NUM_PINS | Per-pin interrupt enable |
| sense_cfg | input | 2*NUM_PINS | Two-bit sense field per pin |
| flag_clr | input | NUM_PINS | Write-one-to-clear strobe per flag |
| irq_ack | input | NUM_PINS | Acknowledge pulse per flag |
| flag | output | NUM_PINS | Sticky edge flags |
| irq | output | NUM_PINS | Interrupt / wake request lines |

## Verification
The clocked properties assume that `int_en`, `sense_cfg`, `flag_clr` and `irq_ack` are synchronous to `clk`. `pin_raw` may move at any time, because it reaches the edge logic only through the synchronizer. The bench changes all of these inputs on the falling clock edge, and it changes a pin in edge mode only after the previous transition has settled through the synchronizer. The clock-stopped cases halt the clock while it is low, so restarting it never produces a runt pulse.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Per-channel registered state
    typedef struct packed {
        logic   prev;   // previous synchronized sample
        sense_e sense;  // sense field seen at the last edge
        logic   flag;   // sticky edge flag
    } chan_state_t;

    function automatic logic edge_match(input sense_e mode, input logic rise, input logic fall);
        logic hit;
        case (mode)
            SENSE_ANY:  hit = rise | fall;
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH    = 2,
    parameter int STAGES   = 2,
    parameter bit RST_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= RST_HIGH ? '1 : '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/extint_channel.sv
module extint_channel
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_raw_i,
    input  logic       pin_sync_i,
    input  logic       en_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    input  logic       ack_i,
    output logic       flag_o,
    output logic       irq_o
);
    chan_state_t state_d, state_q;
    sense_e      mode;
    logic        rise, fall, mode_stable, set_evt, drop;

    always_comb begin
        mode        = sense_e'(sense_i);
        rise        = pin_sync_i & ~state_q.prev;
        fall        = ~pin_sync_i & state_q.prev;
        mode_stable = (mode == state_q.sense);
        set_evt     = en_i & mode_stable & edge_match(mode, rise, fall);
        drop        = clr_i | ack_i;

        state_d       = state_q;
        state_d.prev  = pin_sync_i;
        state_d.sense = mode;
        if (mode == SENSE_LOW) begin
            state_d.flag = 1'b0;
        end else begin
            state_d.flag = set_evt | (state_q.flag & ~drop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{prev: 1'b1, sense: SENSE_LOW, flag: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    // Level request is clock-free so it can wake a gated domain.
    assign irq_o  = (mode == SENSE_LOW) ? (en_i & ~pin_raw_i) : (en_i & state_q.flag);
    assign flag_o = state_q.flag;

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.flag) |-> $past(en_i && (pin_sync_i != state_q.prev))) else $error("flag set without enabled edge"); // R3
    AST_FLAG_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.flag) |-> $past(clr_i || ack_i || sense_i == 2'b00)) else $error("flag lost without clear"); // R4
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == 2'b00) |=> !state_q.flag) else $error("flag in level mode"); // R6
    AST_MODE_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense_i != state_q.sense) && !state_q.flag) |=> !state_q.flag) else $error("mode change set flag"); // R8

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_raw,
    input  logic [NUM_PINS-1:0]   int_en,
    input  logic [2*NUM_PINS-1:0] sense_cfg,
    input  logic [NUM_PINS-1:0]   flag_clr,
    input  logic [NUM_PINS-1:0]   irq_ack,
    output logic [NUM_PINS-1:0]   flag,
    output logic [NUM_PINS-1:0]   irq
);
    localparam int SENSE_W = 2;

    logic [NUM_PINS-1:0] pin_sync;

    extint_sync #(
        .WIDTH    (NUM_PINS),
        .STAGES   (SYNC_STAGES),
        .RST_HIGH (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_raw),
        .sync_o  (pin_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
        extint_channel u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_raw_i  (pin_raw[i]),
            .pin_sync_i (pin_sync[i]),
            .en_i       (int_en[i]),
            .sense_i    (sense_cfg[SENSE_W*i +: SENSE_W]),
            .clr_i      (flag_clr[i]),
            .ack_i      (irq_ack[i]),
            .flag_o     (flag[i]),
            .irq_o      (irq[i])
        );

        AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !int_en[i] |-> !irq[i]) else $error("request from disabled pin"); // R7
    end

endmodule

// File: tb/tb_extint_sense_ctrl.sv
module tb_extint_sense_ctrl;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          clk_run = 1'b1;
    logic          rst_n;
    logic [NP-1:0] pin_raw, int_en, flag_clr, irq_ack, flag, irq;
    logic [2*NP-1:0] sense_cfg;
    int checks = 0;
    int errs   = 0;

    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    extint_sense_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .int_en(int_en),
        .sense_cfg(sense_cfg), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .flag(flag), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        flag_clr = '1;
        tick(1);
        flag_clr = '0;
    endtask

    // {ch, mode[1:0], en, pin_before, pin_after, expected_flag}
    localparam logic [6:0] TBL [10] = '{
        7'b0_10_1_1_0_1,  // fall, falling edge
        7'b0_10_1_0_1_0,  // fall, rising edge ignored
        7'b0_11_1_0_1_1,  // rise, rising edge
        7'b0_11_1_1_0_0,  // rise, falling edge ignored
        7'b0_01_1_1_0_1,  // any, falling
        7'b0_01_1_0_1_1,  // any, rising
        7'b0_10_0_1_0_0,  // disabled
        7'b1_10_1_1_0_1,
        7'b1_11_1_0_1_1,
        7'b1_11_0_0_1_0
    };

    initial begin
        #(200000 * 4);
        errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_raw = '1; int_en = '0; sense_cfg = '0;
        flag_clr = '0; irq_ack = '0;
        tick(3);
        chk("R1 flag in reset", |flag, 1'b0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 flag after reset", |flag, 1'b0);
        chk("R1 irq after reset", |irq, 1'b0);

        // Table walk: R2, R3, R7, R10
        for (int i = 0; i < 10; i++) begin
            automatic logic [6:0] v = TBL[i];
            automatic int ch = int'(v[6]);
            automatic int oc = 1 - ch;
            int_en = '0;
            int_en[ch] = v[3];
            sense_cfg = 4'b1010;
            sense_cfg[2*ch +: 2] = v[5:4];
            pin_raw = '1;
            pin_raw[ch] = v[2];
            tick(5);
            clear_all();
            chk("R4 cleared before vector", flag[ch], 1'b0);
            pin_raw[ch] = v[1];
            tick(2);
            chk("R2 flag not before third edge", flag[ch], 1'b0);
            tick(1);
            chk(v[0] ? "R2 edge sets flag" : "R3 no flag", flag[ch], v[0]);
            chk("R7 irq follows flag", irq[ch], v[0]);
            chk("R10 other pin untouched", flag[oc], 1'b0);
        end

        // R4: sticky, then acknowledge
        int_en = 2'b01; sense_cfg = 4'b1010; pin_raw = '1;
        tick(5); clear_all();
        pin_raw[0] = 1'b0; tick(3);
        pin_raw[0] = 1'b1; tick(5);
        chk("R4 flag sticky", flag[0], 1'b1);
        irq_ack[0] = 1'b1; tick(1); irq_ack[0] = 1'b0;
        chk("R4 ack clears", flag[0], 1'b0);

        // R7: enable hides irq but keeps flag
        pin_raw[0] = 1'b0; tick(3);
        int_en[0] = 1'b0; #1;
        chk("R7 irq hidden", irq[0], 1'b0);
        tick(1);
        chk("R7 flag kept", flag[0], 1'b1);
        int_en[0] = 1'b1; #1;
        chk("R7 irq back", irq[0], 1'b1);

        // R5: set beats clear
        pin_raw[0] = 1'b1; tick(5); clear_all();
        pin_raw[0] = 1'b0; tick(2);
        flag_clr[0] = 1'b1; tick(1); flag_clr[0] = 1'b0;
        chk("R5 set wins", flag[0], 1'b1);

        // R6: level mode, combinational
        sense_cfg = 4'b1000; int_en = 2'b01; pin_raw = '1; tick(3);
        chk("R6 level idle", irq[0], 1'b0);
        pin_raw[0] = 1'b0; #1;
        chk("R6 level low no clock", irq[0], 1'b1);
        tick(3);
        chk("R6 level flag zero", flag[0], 1'b0);
        chk("R6 level held", irq[0], 1'b1);
        pin_raw[0] = 1'b1; #1;
        chk("R6 level release", irq[0], 1'b0);

        // R9 and R6 with clock stopped
        sense_cfg = 4'b1100; int_en = 2'b11; pin_raw = 2'b01;
        tick(5); clear_all();
        clk_run = 1'b0;
        #20 pin_raw[0] = 1'b0;
        #10 chk("R6 wake with clock stopped", irq[0], 1'b1);
        pin_raw[1] = 1'b1;
        #40;
        chk("R9 no flag while stopped", flag[1], 1'b0);
        chk("R9 no irq while stopped", irq[1], 1'b0);
        pin_raw = 2'b11;
        clk_run = 1'b1;
        tick(5); clear_all();

        // R8: mode change suppresses in-flight edge
        sense_cfg = 4'b1011; int_en = 2'b01; pin_raw[0] = 1'b0;
        tick(5); clear_all();
        pin_raw[0] = 1'b1; tick(2);
        sense_cfg[1:0] = 2'b01;
        tick(1);
        chk("R8 edge dropped on mode change", flag[0], 1'b0);
        sense_cfg[1:0] = 2'b00; tick(3);
        pin_raw[0] = 1'b0; tick(5);
        sense_cfg[1:0] = 2'b10; tick(3);
        chk("R8 level to edge no event", flag[0], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule